// File: doc/BRIEF.md
# Four-Function ALU with Unsigned and Signed Condition Flags

This block is a small combinational arithmetic unit. Two narrow operands arrive, each is widened to the datapath width by copying its sign bit, and a two-bit function code picks one of four results: sum, difference, product or bitwise conjunction. The chosen value leaves on the result port.

Alongside the result the block reports six condition flags. Four of them describe the sum and the difference whatever function is chosen. The carry and borrow flags read the widened operands as unsigned numbers. The two overflow flags, one for addition and one for subtraction, read them as two's-complement numbers. Software can therefore test for any of these conditions after any operation. Each of these four flags is built from the top bits of the operands and of the relevant arithmetic result. The negative and zero flags describe the result that was actually selected. There is no clock and no state, so every output follows its inputs in the same cycle.

Top module: `alu_top`

## Requirements
- R1: Each 4-bit operand is widened to 8 bits by replicating its bit 3. For example, operand 4'b1010 enters every function as 8'hFA.
- R2: Function code 2'b00 gives the low 8 bits of the sum of the widened operands, and 2'b01 gives the low 8 bits of their difference (first operand minus second).
- R3: Function code 2'b10 gives the low 8 bits of the product of the widened operands.
- R4: Function code 2'b11 gives the bitwise AND of the widened operands.
- R5: Flag bit 5 (carry) is 1 exactly when the 8-bit unsigned sum of the widened operands exceeds 255, whatever the function code.
- R6: Flag bit 4 (borrow) is 1 exactly when the widened first operand, read as unsigned, is less than the widened second operand, whatever the function code.
- R7: Flag bit 3 (add overflow) is 1 exactly when the signed sum of the widened operands falls outside -128..127, whatever the function code.
- R8: Flag bit 2 (subtract overflow) is 1 exactly when the signed difference of the widened operands falls outside -128..127, whatever the function code.
- R9: Flag bit 1 (negative) equals bit 7 of the selected result.
- R10: Flag bit 0 (zero) is 1 exactly when all 8 bits of the selected result are 0.
- R11: The result and flags depend only on the present inputs. They settle in the cycle in which the inputs change and keep no value from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4 | First operand, two's complement |
| opb_i | input | 4 | Second operand, two's complement |
| op_i | input | 2 | Function code: 00 add, 01 subtract, 10 multiply, 11 AND |
| result_o | output | 8 | Selected 8-bit result |
| flags_o | output | 6 | {carry, borrow, add overflow, subtract overflow, negative, zero} |

## Verification
The block holds no state, so a wrong internal signal can only be a wrong wire: a sign bit that was not replicated, a swapped term in a flag equation, or a function code that selects the wrong input. Any of these shows at the ports on the very input pattern that uses it, in the same cycle. Driving all operand pairs under all four function codes therefore reaches every such fault at once. Because the flags come from fixed equations rather than from the selected result, a swap between the add-side and subtract-side terms shows up even while the multiply or AND function is selected.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_AND = 2'b11
  } alu_op_e;

  localparam int FLAG_W   = 6;
  localparam int FL_CARRY = 5;
  localparam int FL_BORR  = 4;
  localparam int FL_VADD  = 3;
  localparam int FL_VSUB  = 2;
  localparam int FL_NEG   = 1;
  localparam int FL_ZERO  = 0;

endpackage

// File: rtl/alu_sext.sv
module alu_sext #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  narrow_i,
  output logic [OUT_W-1:0] wide_o
);

  localparam int EXT_W = OUT_W - IN_W;

  assign wide_o[IN_W-1:0] = narrow_i;

  // Copy the sign bit into every upper position.
  for (genvar g = 0; g < EXT_W; g++) begin : g_ext
    assign wide_o[IN_W+g] = narrow_i[IN_W-1];
  end

endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic [W-1:0] prod_o,
  output logic [W-1:0] conj_o
);

  // The low W bits of a product do not depend on signedness.
  always_comb begin
    sum_o  = a_i + b_i;
    diff_o = a_i - b_i;
    prod_o = a_i * b_i;
    conj_o = a_i & b_i;
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              a_msb_i,
  input  logic              b_msb_i,
  input  logic [W-1:0]      sum_i,
  input  logic [W-1:0]      diff_i,
  input  logic [W-1:0]      res_i,
  output logic [FLAG_W-1:0] flags_o
);

  logic sm, dm;

  always_comb begin
    sm = sum_i[W-1];
    dm = diff_i[W-1];

    // Unsigned carry out of the sum.
    flags_o[FL_CARRY] = (a_msb_i & b_msb_i) | (a_msb_i & ~sm) | (b_msb_i & ~sm);
    // Unsigned borrow out of the difference.
    flags_o[FL_BORR]  = (~a_msb_i & b_msb_i) | (b_msb_i & dm) | (~a_msb_i & dm);
    // Signed overflow: like-signed addends giving an opposite sign.
    flags_o[FL_VADD]  = (~a_msb_i & ~b_msb_i & sm) | (a_msb_i & b_msb_i & ~sm);
    // Signed overflow: unlike-signed subtraction giving the subtrahend's sign.
    flags_o[FL_VSUB]  = (a_msb_i & ~b_msb_i & ~dm) | (~a_msb_i & b_msb_i & dm);
    flags_o[FL_NEG]   = res_i[W-1];
    flags_o[FL_ZERO]  = ~|res_i;
  end

endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int IN_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic [IN_W-1:0]   opa_i,
  input  logic [IN_W-1:0]   opb_i,
  input  logic [1:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);

  logic [DATA_W-1:0] wa, wb;
  logic [DATA_W-1:0] sum, diff, prod, conj;
  logic [DATA_W-1:0] res;
  alu_op_e           op;

  alu_sext #(.IN_W(IN_W), .OUT_W(DATA_W)) u_sext_a (.narrow_i(opa_i), .wide_o(wa));
  alu_sext #(.IN_W(IN_W), .OUT_W(DATA_W)) u_sext_b (.narrow_i(opb_i), .wide_o(wb));

  alu_arith #(.W(DATA_W)) u_arith (
    .a_i   (wa),
    .b_i   (wb),
    .sum_o (sum),
    .diff_o(diff),
    .prod_o(prod),
    .conj_o(conj)
  );

  always_comb begin
    op = alu_op_e'(op_i);
    unique case (op)
      OP_ADD:  res = sum;
      OP_SUB:  res = diff;
      OP_MUL:  res = prod;
      OP_AND:  res = conj;
      default: res = '0;
    endcase
  end

  alu_flags #(.W(DATA_W)) u_flags (
    .a_msb_i(wa[DATA_W-1]),
    .b_msb_i(wb[DATA_W-1]),
    .sum_i  (sum),
    .diff_i (diff),
    .res_i  (res),
    .flags_o(flags_o)
  );

  assign result_o = res;

endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
  parameter int IN_W   = 4,
  parameter int DATA_W = 8
) (
  input logic [IN_W-1:0]   opa_i,
  input logic [IN_W-1:0]   opb_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] result_o,
  input logic [5:0]        flags_o
);

  localparam int MOD  = 2 ** DATA_W;
  localparam int SMAX = 2 ** (DATA_W - 1) - 1;
  localparam int SMIN = -(2 ** (DATA_W - 1));

  int sa, sb, ua, ub, s_sum, s_dif;

  always_comb begin
    sa    = int'($signed(opa_i));
    sb    = int'($signed(opb_i));
    ua    = (sa + MOD) % MOD;
    ub    = (sb + MOD) % MOD;
    s_sum = sa + sb;
    s_dif = sa - sb;

    a_r5_carry:   assert (flags_o[5] == ((ua + ub) >= MOD));
    a_r6_borrow:  assert (flags_o[4] == (ua < ub));
    a_r7_add_ovf: assert (flags_o[3] == (s_sum > SMAX || s_sum < SMIN));
    a_r8_sub_ovf: assert (flags_o[2] == (s_dif > SMAX || s_dif < SMIN));
    a_r9_neg:     assert (flags_o[1] == result_o[DATA_W-1]);
    a_r10_zero:   assert (flags_o[0] == (result_o == '0));
    if (op_i == 2'b00) begin
      a_r2_add:   assert (int'(result_o) == (s_sum + MOD) % MOD);
    end
  end

endmodule

bind alu_top alu_chk #(.IN_W(IN_W), .DATA_W(DATA_W)) u_chk (
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .op_i    (op_i),
  .result_o(result_o),
  .flags_o (flags_o)
);

// File: tb/alu_top_tb_top.sv
module alu_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] opa, opb;
  logic [1:0] op;
  logic [7:0] res;
  logic [5:0] flg;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #4 clk = ~clk;

  alu_top dut_i (
    .opa_i   (opa),
    .opb_i   (opb),
    .op_i    (op),
    .result_o(res),
    .flags_o (flg)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h op=%0d got=%0h exp=%0h", req, opa, opb, op, got, exp);
    end
  endtask

  function automatic int sx(logic [3:0] v);
    return v[3] ? int'(v) - 16 : int'(v);
  endfunction

  task automatic apply(logic [3:0] a, logic [3:0] b, logic [1:0] o);
    @(posedge clk);
    opa = a; opb = b; op = o;
    @(negedge clk);
  endtask

  task automatic compare();
    int sa, sb, r, e, ua, ub;
    sa = sx(opa); sb = sx(opb);
    ua = sa & 255; ub = sb & 255;
    case (op)
      2'b00:   r = sa + sb;
      2'b01:   r = sa - sb;
      2'b10:   r = sa * sb;
      default: r = sa & sb;
    endcase
    e = r & 255;
    case (op)
      2'b00, 2'b01: check("R2", int'(res), e);
      2'b10:        check("R3", int'(res), e);
      default:      check("R4", int'(res), e);
    endcase
    check("R5",  int'(flg[5]), int'((ua + ub) > 255));
    check("R6",  int'(flg[4]), int'(ua < ub));
    check("R7",  int'(flg[3]), int'((sa + sb) > 127 || (sa + sb) < -128));
    check("R8",  int'(flg[2]), int'((sa - sb) > 127 || (sa - sb) < -128));
    check("R9",  int'(flg[1]), (e >> 7) & 1);
    check("R10", int'(flg[0]), int'(e == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    opa = '0; opb = '0; op = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Idle state: zero inputs give zero result and only the zero flag.
    check("R10", int'(res), 0);
    check("R10", int'(flg), 6'b000001);
    rst_n = 1'b1;

    // R1: AND with all-ones second operand exposes the widened first operand.
    for (int a = 0; a < 16; a++) begin
      apply(4'(a), 4'hF, 2'b11);
      check("R1", int'(res), sx(4'(a)) & 255);
    end

    // Exhaustive sweep under every function code.
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          apply(4'(a), 4'(b), 2'(o));
          compare();
        end

    // R11: change inputs mid-cycle; the outputs follow with no clock edge.
    apply(4'h7, 4'h7, 2'b10);
    #1;
    opa = 4'h0;
    #1;
    check("R11", int'(res), 0);
    check("R11", int'(flg[0]), 1);
    opa = 4'h8; opb = 4'h8; op = 2'b00;
    #1;
    check("R11", int'(res), 8'hF0);
    check("R11", int'(flg[5]), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule